// File: doc/BRIEF.md
# Program Flow Control Unit

This block sequences the control-transfer instructions of a small 8-bit processor. It takes one byte at a time from a fetch interface. It decides whether each byte is an opcode or an operand. It decodes jump, call, return and restart opcodes and keeps a 14-bit program counter that always names the address of the next byte to fetch.

Conditional forms test a 3-bit condition field against four status flags, which the surrounding datapath supplies as inputs. Calls and restarts save a return address on an internal seven-entry stack, and returns take it back. A few reserved opcodes stop the unit until the next reset.

For opcodes that are not flow instructions, the unit only needs to know how many operand bytes follow. A side input gives that length together with the opcode byte. The unit then steps over those bytes without decoding them.

Top module: `flow_ctrl`

## Requirements
- R1: After reset the program counter is 0, `halted` is 0, `at_opcode` is 1 and the return stack is empty (stack pointer 0).
- R2: A condition field c[2:0] uses c[1:0] to pick a flag: 0 picks carry, 1 picks zero, 2 picks sign and 3 picks `flag_parity_even` (1 means even parity, which counts as true). The condition holds when the picked flag equals c[2], so c[2]=1 means "if set" and c[2]=0 means "if clear". The flags are sampled with the opcode byte.
- R3: Opcode 01ccc000 is a conditional jump followed by a target low byte and then a target high byte. When the condition holds, the program counter becomes {high[5:0], low}, and target bits 15:14 are dropped. Otherwise it ends 3 past the opcode address. Each operand byte advances the counter by one while it is pending.
- R4: Opcode 01xxx100 jumps to the target for every value of bits 5:3 and every flag setting.
- R5: Opcode 01ccc010 (conditional) and opcode 01xxx110 (always) are calls. A call that is taken pushes the address just after the high byte and loads the target. A call that is not taken still consumes both address bytes and pushes nothing.
- R6: Opcode 00ccc011 (conditional) and opcode 00xxx111 (always) are returns. A return that is taken pops the stack into the program counter. A return that is not taken advances the counter by one.
- R7: Opcode 00nnn101 is a restart. It pushes the opcode address plus one and loads the program counter with nnn times 8.
- R8: An opcode byte of 0x00, 0x01 or 0xFF sets `halted`. The program counter keeps the address of that byte, and every later byte is ignored until reset. The same values arriving as operand bytes do not halt the unit.
- R9: Any other opcode advances the program counter by 1 plus `op_len`, and an `op_len` of 3 is treated as 2. Its operand bytes are not decoded. `at_opcode` is 0 while they are pending.
- R10: The return stack holds 7 entries and its pointer wraps modulo 7. An eighth push overwrites the oldest entry. Pops after that return entries in reverse order, and the wrapped pointer goes back to the overwritten slot.
- R11: A cycle without `byte_valid` changes neither the program counter nor the instruction phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_valid | input | 1 | A fetched byte is present this cycle |
| byte_data | input | 8 | Fetched opcode or operand byte |
| op_len | input | 2 | Operand count of a non-flow opcode, sampled with the opcode |
| flag_carry | input | 1 | Carry flag |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_parity_even | input | 1 | 1 when the result has even parity |
| pc | output | 14 | Address of the next byte to fetch |
| halted | output | 1 | Unit has stopped on a halt opcode |
| at_opcode | output | 1 | Next accepted byte is decoded as an opcode |

## Verification
Every result is registered. A byte presented before a clock edge therefore shows its effect on `pc`, `halted` and `at_opcode` just after that same edge, and the outcome of an instruction is complete one edge after its last byte. The bench changes inputs one time unit after each rising edge and reads the outputs before the next one, so each check sees exactly the state left by the bytes sent so far. Internal reset release takes two further edges, and the bench waits for them before it sends the first byte.

// File: rtl/flow_ctrl_pkg.sv
package flow_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_HALT  = 3'd1,
    K_JUMP  = 3'd2,
    K_CALL  = 3'd3,
    K_RET   = 3'd4,
    K_RST   = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       cond;
    logic [2:0] field;
  } dec_t;

endpackage

// File: rtl/flow_ctrl_decode.sv
module flow_ctrl_decode
  import flow_ctrl_pkg::*;
(
  input  logic [7:0] opc,
  output dec_t       dec
);

  always_comb begin
    dec.kind  = K_OTHER;
    dec.cond  = 1'b0;
    dec.field = opc[5:3];
    if (opc == 8'h00 || opc == 8'h01 || opc == 8'hFF) begin
      dec.kind = K_HALT;
    end else if (opc[7:6] == 2'b01) begin
      unique case (opc[2:0])
        3'b000:  begin dec.kind = K_JUMP; dec.cond = 1'b1; end
        3'b010:  begin dec.kind = K_CALL; dec.cond = 1'b1; end
        3'b100:  dec.kind = K_JUMP;
        3'b110:  dec.kind = K_CALL;
        default: dec.kind = K_OTHER;
      endcase
    end else if (opc[7:6] == 2'b00) begin
      unique case (opc[2:0])
        3'b011:  begin dec.kind = K_RET; dec.cond = 1'b1; end
        3'b111:  dec.kind = K_RET;
        3'b101:  dec.kind = K_RST;
        default: dec.kind = K_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/flow_ctrl_cond.sv
module flow_ctrl_cond #(
  parameter int N_FLAGS = 4,
  localparam int SEL_W  = $clog2(N_FLAGS)
) (
  input  logic [SEL_W:0]     field,
  input  logic [N_FLAGS-1:0] flags,
  output logic               hold
);

  // top bit of field is the wanted polarity, low bits pick the flag
  always_comb begin
    hold = (flags[field[SEL_W-1:0]] == field[SEL_W]);
  end

endmodule

// File: rtl/flow_ctrl_stack.sv
module flow_ctrl_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 7,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q, sp_d, sp_prev, sp_next;

  always_comb begin
    sp_prev = (sp_q == '0) ? SP_W'(DEPTH - 1) : sp_q - SP_W'(1);
    sp_next = (sp_q == SP_W'(DEPTH - 1)) ? '0 : sp_q + SP_W'(1);
    sp_d    = sp_q;
    if (push)     sp_d = sp_next;
    else if (pop) sp_d = sp_prev;
    rd_data = mem[sp_prev];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sp_q <= '0;
    else if (push || pop) sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= wr_data;
  end

endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_ctrl_pkg::*;
#(
  parameter int PC_W      = 14,
  parameter int STK_DEPTH = 7,
  localparam int BYTE_W   = 8,
  localparam int TGT_W    = 2 * BYTE_W,
  localparam int MAX_OPS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [1:0]        op_len,
  input  logic              flag_carry,
  input  logic              flag_zero,
  input  logic              flag_sign,
  input  logic              flag_parity_even,
  output logic [PC_W-1:0]   pc,
  output logic              halted,
  output logic              at_opcode
);

  // reset: asserted at once, released after two edges
  logic rst_s0_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0_q   <= 1'b1;
      rst_sync_n <= rst_s0_q;
    end
  end

  phase_e            phase_q, phase_d;
  logic [PC_W-1:0]   pc_q, pc_d, pc_inc;
  logic              halted_q, halted_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              take_q, take_d, call_q, call_d;
  logic [1:0]        skip_q, skip_d, len_eff;
  logic              accept, cond_ok, push, pop;
  logic [PC_W-1:0]   pop_data;
  logic [TGT_W-1:0]  target;
  dec_t              dec;

  flow_ctrl_decode u_dec (
    .opc (byte_data),
    .dec (dec)
  );

  flow_ctrl_cond #(.N_FLAGS(4)) u_cond (
    .field (dec.field),
    .flags ({flag_parity_even, flag_sign, flag_zero, flag_carry}),
    .hold  (cond_ok)
  );

  flow_ctrl_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push    (push),
    .pop     (pop),
    .wr_data (pc_inc),
    .rd_data (pop_data)
  );

  always_comb begin
    accept  = byte_valid && !halted_q;
    pc_inc  = pc_q + PC_W'(1);
    target  = {byte_data, lo_q};
    len_eff = (op_len > 2'(MAX_OPS)) ? 2'(MAX_OPS) : op_len;

    phase_d  = phase_q;
    pc_d     = pc_q;
    halted_d = halted_q;
    lo_d     = lo_q;
    take_d   = take_q;
    call_d   = call_q;
    skip_d   = skip_q;
    push     = 1'b0;
    pop      = 1'b0;

    if (accept) begin
      unique case (phase_q)
        PH_OPC: begin
          unique case (dec.kind)
            K_HALT: halted_d = 1'b1;
            K_RET: begin
              if (!dec.cond || cond_ok) begin
                pop  = 1'b1;
                pc_d = pop_data;
              end else begin
                pc_d = pc_inc;
              end
            end
            K_RST: begin
              push      = 1'b1;
              pc_d      = '0;
              pc_d[5:0] = {dec.field, 3'b000};
            end
            K_JUMP, K_CALL: begin
              take_d  = !dec.cond || cond_ok;
              call_d  = (dec.kind == K_CALL);
              pc_d    = pc_inc;
              phase_d = PH_LO;
            end
            default: begin
              pc_d = pc_inc;
              if (len_eff != 2'd0) begin
                skip_d  = len_eff;
                phase_d = PH_SKIP;
              end
            end
          endcase
        end
        PH_LO: begin
          lo_d    = byte_data;
          pc_d    = pc_inc;
          phase_d = PH_HI;
        end
        PH_HI: begin
          phase_d = PH_OPC;
          if (take_q) begin
            pc_d = PC_W'(target);
            push = call_q;
          end else begin
            pc_d = pc_inc;
          end
        end
        default: begin
          pc_d   = pc_inc;
          skip_d = skip_q - 2'd1;
          if (skip_q == 2'd1) phase_d = PH_OPC;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q  <= PH_OPC;
      pc_q     <= '0;
      halted_q <= 1'b0;
      lo_q     <= '0;
      take_q   <= 1'b0;
      call_q   <= 1'b0;
      skip_q   <= '0;
    end else if (accept) begin
      phase_q  <= phase_d;
      pc_q     <= pc_d;
      halted_q <= halted_d;
      lo_q     <= lo_d;
      take_q   <= take_d;
      call_q   <= call_d;
      skip_q   <= skip_d;
    end
  end

  assign pc        = pc_q;
  assign halted    = halted_q;
  assign at_opcode = (phase_q == PH_OPC);

endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk
  import flow_ctrl_pkg::*;
#(
  parameter int PC_W = 14
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            byte_valid,
  input logic [7:0]      byte_data,
  input logic [PC_W-1:0] pc,
  input logic            halted,
  input logic            at_opcode,
  input phase_e          phase
);

  logic opc_in;
  assign opc_in = byte_valid && at_opcode && !halted;

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    halted |=> halted && $stable(pc));

  // R8
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    opc_in && (byte_data == 8'h00 || byte_data == 8'h01 || byte_data == 8'hFF)
    |=> halted);

  // R7
  rst_vector_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    opc_in && byte_data[7:6] == 2'b00 && byte_data[2:0] == 3'b101
    |=> pc == PC_W'({$past(byte_data[5:3]), 3'b000}));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !byte_valid |=> $stable(pc) && $stable(at_opcode));

  // R3
  lo_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    byte_valid && !halted && phase == PH_LO |=> pc == $past(pc) + PC_W'(1));

  // R4
  jump_operands_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    opc_in && byte_data[7:6] == 2'b01 && byte_data[2:0] == 3'b100
    |=> !at_opcode);

endmodule

bind flow_ctrl flow_ctrl_chk #(.PC_W(PC_W)) u_flow_ctrl_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .pc         (pc),
  .halted     (halted),
  .at_opcode  (at_opcode),
  .phase      (phase_q)
);

// File: tb/test_flow_ctrl.sv
module test_flow_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [1:0]  op_len = 2'd0;
  logic [3:0]  flg = 4'h0;
  logic [13:0] pc;
  logic        halted, at_opcode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flow_ctrl i_flow_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .byte_valid       (byte_valid),
    .byte_data        (byte_data),
    .op_len           (op_len),
    .flag_carry       (flg[0]),
    .flag_zero        (flg[1]),
    .flag_sign        (flg[2]),
    .flag_parity_even (flg[3]),
    .pc               (pc),
    .halted           (halted),
    .at_opcode        (at_opcode)
  );

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(posedge clk);
    #1 byte_valid = 1'b0;
  endtask

  function automatic bit cond_true(input int c, input logic [3:0] f);
    return f[c % 4] == c[2];
  endfunction

  initial begin
    logic [13:0] p, t, r;
    logic [7:0]  lo, hi;
    logic [13:0] rets [1:8];

    do_reset();
    // R1
    check("R1 pc", int'(pc), 0);
    check("R1 halted", int'(halted), 0);
    check("R1 at_opcode", int'(at_opcode), 1);

    // R2 R3: conditional jump over every code and flag setting
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        flg = 4'(f);
        p  = pc;
        lo = {3'(c), 4'(f), 1'b1};
        hi = {2'b11, 4'(f), 2'(c)};
        t  = {hi[5:0], lo};
        put(8'h40 | 8'(c << 3));
        put(lo);
        check("R3 after low byte", int'(pc), int'(14'(p + 14'd2)));
        put(hi);
        check("R2 R3 jump result", int'(pc),
              cond_true(c, 4'(f)) ? int'(t) : int'(14'(p + 14'd3)));
      end
    end

    // R4: unconditional jump ignores bits 5:3 and flags
    for (int x = 0; x < 8; x++) begin
      for (int k = 0; k < 2; k++) begin
        flg = (k == 0) ? 4'h0 : 4'hF;
        lo  = 8'(x * 17 + k);
        put(8'h44 | 8'(x << 3));
        put(lo);
        put(8'h2A);
        check("R4 jump", int'(pc), int'({6'h2A, lo}));
      end
    end

    // R5: conditional call, then unconditional return
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        flg = 4'(f);
        p  = pc;
        lo = 8'(c * 16 + f);
        t  = {6'h15, lo};
        put(8'h42 | 8'(c << 3));
        put(lo);
        put(8'h15);
        if (cond_true(c, 4'(f))) begin
          check("R5 call taken", int'(pc), int'(t));
          put(8'h07 | 8'(c << 3));
          check("R6 return after call", int'(pc), int'(14'(p + 14'd3)));
        end else begin
          check("R5 call not taken", int'(pc), int'(14'(p + 14'd3)));
        end
      end
    end

    // R6: conditional return
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        flg = 4'h0;
        p  = pc;
        lo = 8'(f * 8 + c);
        t  = {6'h09, lo};
        put(8'h46);
        put(lo);
        put(8'h09);
        flg = 4'(f);
        put(8'h03 | 8'(c << 3));
        if (cond_true(c, 4'(f))) begin
          check("R6 cond return taken", int'(pc), int'(14'(p + 14'd3)));
        end else begin
          check("R6 cond return skipped", int'(pc), int'(14'(t + 14'd1)));
          put(8'h3F);
          check("R6 plain return", int'(pc), int'(14'(p + 14'd3)));
        end
      end
    end

    // R7: restart vectors
    for (int n = 0; n < 8; n++) begin
      p = pc;
      put(8'h05 | 8'(n << 3));
      check("R7 restart vector", int'(pc), n * 8);
      put(8'h07);
      check("R7 restart return", int'(pc), int'(14'(p + 14'd1)));
    end

    // R9: non-flow opcodes with every operand length
    for (int len = 0; len < 4; len++) begin
      int n;
      n = (len == 3) ? 2 : len;
      p = pc;
      op_len = 2'(len);
      put(8'h80 | 8'(len));
      op_len = 2'd0;
      check("R9 operand pending", int'(at_opcode), (n == 0) ? 1 : 0);
      for (int k = 0; k < n; k++) put(8'hFF);
      check("R9 pc advance", int'(pc), int'(14'(p + 14'(1 + n))));
      check("R8 operand 0xFF not halting", int'(halted), 0);
      check("R9 back at opcode", int'(at_opcode), 1);
    end

    // R11: idle cycles in the middle of a jump
    p = pc;
    put(8'h44);
    put(8'h00);
    repeat (4) @(posedge clk);
    #1;
    check("R11 idle pc", int'(pc), int'(14'(p + 14'd2)));
    check("R11 idle phase", int'(at_opcode), 0);
    put(8'h01);
    check("R8 operand 0x00/0x01 not halting", int'({halted, pc}), int'({1'b0, 14'h0100}));

    // R10: eight calls wrap the seven-entry stack
    do_reset();
    for (int i = 1; i <= 8; i++) begin
      p = pc;
      rets[i] = 14'(p + 14'd3);
      put(8'h46);
      put(8'h10);
      put(8'(i));
      check("R10 call", int'(pc), int'({6'(i), 8'h10}));
    end
    for (int k = 1; k <= 8; k++) begin
      put(8'h07);
      r = (k <= 7) ? rets[9 - k] : rets[8];
      check("R10 wrapped pop", int'(pc), int'(r));
    end

    // R8: halt opcodes
    for (int h = 0; h < 3; h++) begin
      logic [7:0] hop;
      hop = (h == 0) ? 8'h00 : (h == 1) ? 8'h01 : 8'hFF;
      do_reset();
      put(8'h44);
      put(8'h34);
      put(8'h12);
      put(hop);
      check("R8 halted set", int'(halted), 1);
      check("R8 pc held", int'(pc), 14'h1234);
      put(8'h44);
      put(8'h00);
      put(8'h00);
      check("R8 bytes ignored", int'({halted, at_opcode, pc}), int'({2'b11, 14'h1234}));
    end

    do_reset();
    check("R1 reset clears halt", int'({halted, pc}), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule